// File: doc/BRIEF.md
# Configurable PLD output macrocell

This block is a bank of output cells for a small programmable logic device. Each cell receives a sum-of-products result from the logic array and an output-enable product term of its own. It drives a three-state pin, modelled as a value and an enable. It also returns a feedback bit to the array. Two static configuration bits per cell choose one of four cell modes: registered or combinational, each with an active-high or active-low pin. All cells share one clock, an asynchronous-clear product term, a synchronous-set product term, a power-on reset and a test-load mode input.

Each cell has a single D flip-flop that holds an active-high state bit. A rising clock edge loads that flip-flop from one of three load sources: the set constant, the pin value in test-load mode, or the sum term. The asynchronous clear forces the state to 0 at once. The cell's mode selects the pin value and the feedback. In a registered mode the pin shows the state bit after polarity, and the feedback is the state bit. In a combinational mode the pin shows the sum term after polarity, and the feedback is the level actually present on the pin. A cell whose enable term is never asserted therefore serves as an input pin. The bit that selects combinational operation is called S1 below, and the active-high bit is called S0. The four cell modes are MODE_REG_LOW, MODE_REG_HIGH, MODE_COMB_LOW and MODE_COMB_HIGH. The load sources are LD_SET, LD_PIN and LD_SUM, and a clear overrides all of them.

Top module: `pld_macrocell`

## Requirements
- R1: The mode is {cfg_comb, cfg_pol_high} = {S1, S0}: 00 is MODE_REG_LOW, 01 is MODE_REG_HIGH, 10 is MODE_COMB_LOW and 11 is MODE_COMB_HIGH. In a combinational mode pin_out equals sum_term when S0 = 1 and its inverse when S0 = 0, and it follows sum_term without a clock edge.
- R2: With no clear, no set and no test load, a rising clock edge loads the state bit from sum_term (transition LD_SUM).
- R3: In a registered mode fb equals the state bit. In a combinational mode fb equals pin_in.
- R4: While ar_term is 1, the state bit is 0, immediately and with no clock edge.
- R5: When sp_term is 1 and ar_term is 0, the next rising edge sets the state bit to 1 (transition LD_SET). ar_term wins over sp_term, and sp_term wins over both sum and pin loading.
- R6: In a registered mode pin_out equals the state bit when S0 = 1 and its inverse when S0 = 0. Clear and set act on the state bit, not on the pin level.
- R7: With preload_en at 0, pin_oe equals oe_term. A cell with oe_term at 0 in a combinational mode passes the external pin level to fb.
- R8: While preload_en is 1, every pin_oe is 0, and a rising edge with no set or clear loads the state bit from pin_in (transition LD_PIN).
- R9: While rst_n is 0, every state bit is 0, so a registered cell shows 1 in MODE_REG_LOW and 0 in MODE_REG_HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ar_term | input | 1 | Shared asynchronous-clear product term |
| sp_term | input | 1 | Shared synchronous-set product term |
| preload_en | input | 1 | Test-load mode (disables pins, loads state from pins) |
| cfg_comb | input | N_CELLS | Per-cell S1: 1 bypasses the flip-flop |
| cfg_pol_high | input | N_CELLS | Per-cell S0: 1 gives an active-high pin |
| sum_term | input | N_CELLS | Per-cell sum-of-products result |
| oe_term | input | N_CELLS | Per-cell output-enable product term |
| pin_in | input | N_CELLS | Level observed on each pin |
| pin_out | output | N_CELLS | Value driven toward each pin |
| pin_oe | output | N_CELLS | Driver enable for each pin |
| fb | output | N_CELLS | Feedback to the logic array |

## Verification
The bench builds the bank with N_CELLS = 4 and gives each cell a different mode, so that all four modes run side by side under the same shared clear, set and test-load terms. One vector can then show the priority between clear, set and load on registered and combinational cells at once. Turning individual enables off lets the bench drive pin levels of its own, which brings the input-pin path, the pin-sourced feedback and the test-load capture within reach.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

    // Cell mode, encoded as {S1, S0}.
    typedef enum logic [1:0] {
        MODE_REG_LOW   = 2'b00,
        MODE_REG_HIGH  = 2'b01,
        MODE_COMB_LOW  = 2'b10,
        MODE_COMB_HIGH = 2'b11
    } mc_mode_e;

    // Source loaded into the state bit on a rising edge.
    typedef enum logic [1:0] {
        LD_SUM = 2'b00,
        LD_PIN = 2'b01,
        LD_SET = 2'b10
    } mc_load_e;

endpackage

// File: rtl/pld_mc_store.sv
module pld_mc_store
    import pld_mc_pkg::*;
(
    input  logic clk,
    input  logic clr_async,
    input  logic set_sync,
    input  logic load_pin,
    input  logic sum_bit,
    input  logic pin_bit,
    output logic state_q
);

    mc_load_e load_src;
    logic     next_bit;

    // Priority: set over pin load over sum load (clear is asynchronous).
    always_comb begin
        if (set_sync)
            load_src = LD_SET;
        else if (load_pin)
            load_src = LD_PIN;
        else
            load_src = LD_SUM;
    end

    always_comb begin
        unique case (load_src)
            LD_SET:  next_bit = 1'b1;
            LD_PIN:  next_bit = pin_bit;
            LD_SUM:  next_bit = sum_bit;
            default: next_bit = sum_bit;
        endcase
    end

    always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async)
            state_q <= 1'b0;
        else
            state_q <= next_bit;
    end

endmodule

// File: rtl/pld_mc_route.sv
module pld_mc_route
    import pld_mc_pkg::*;
(
    input  logic sel_comb,
    input  logic sel_high,
    input  logic state_q,
    input  logic sum_bit,
    input  logic pin_bit,
    input  logic oe_bit,
    input  logic test_load,
    output logic drive_val,
    output logic drive_en,
    output logic fb_bit
);

    mc_mode_e mode;

    assign mode = mc_mode_e'({sel_comb, sel_high});

    always_comb begin
        unique case (mode)
            MODE_REG_LOW: begin
                drive_val = ~state_q;
                fb_bit    = state_q;
            end
            MODE_REG_HIGH: begin
                drive_val = state_q;
                fb_bit    = state_q;
            end
            MODE_COMB_LOW: begin
                drive_val = ~sum_bit;
                fb_bit    = pin_bit;
            end
            MODE_COMB_HIGH: begin
                drive_val = sum_bit;
                fb_bit    = pin_bit;
            end
            default: begin
                drive_val = state_q;
                fb_bit    = state_q;
            end
        endcase
    end

    // Test-load mode releases every pin so the tester can drive it.
    assign drive_en = oe_bit & ~test_load;

endmodule

// File: rtl/pld_mc_cell.sv
module pld_mc_cell (
    input  logic clk,
    input  logic clr_async,
    input  logic set_sync,
    input  logic test_load,
    input  logic sel_comb,
    input  logic sel_high,
    input  logic sum_bit,
    input  logic oe_bit,
    input  logic pin_bit,
    output logic drive_val,
    output logic drive_en,
    output logic fb_bit
);

    logic state_q;

    pld_mc_store u_store (
        .clk       (clk),
        .clr_async (clr_async),
        .set_sync  (set_sync),
        .load_pin  (test_load),
        .sum_bit   (sum_bit),
        .pin_bit   (pin_bit),
        .state_q   (state_q)
    );

    pld_mc_route u_route (
        .sel_comb  (sel_comb),
        .sel_high  (sel_high),
        .state_q   (state_q),
        .sum_bit   (sum_bit),
        .pin_bit   (pin_bit),
        .oe_bit    (oe_bit),
        .test_load (test_load),
        .drive_val (drive_val),
        .drive_en  (drive_en),
        .fb_bit    (fb_bit)
    );

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
    parameter int N_CELLS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ar_term,
    input  logic               sp_term,
    input  logic               preload_en,
    input  logic [N_CELLS-1:0] cfg_comb,
    input  logic [N_CELLS-1:0] cfg_pol_high,
    input  logic [N_CELLS-1:0] sum_term,
    input  logic [N_CELLS-1:0] oe_term,
    input  logic [N_CELLS-1:0] pin_in,
    output logic [N_CELLS-1:0] pin_out,
    output logic [N_CELLS-1:0] pin_oe,
    output logic [N_CELLS-1:0] fb
);

    logic clr_any;

    // Power-on reset and the clear term share one asynchronous path.
    assign clr_any = ar_term | ~rst_n;

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        pld_mc_cell u_cell (
            .clk       (clk),
            .clr_async (clr_any),
            .set_sync  (sp_term),
            .test_load (preload_en),
            .sel_comb  (cfg_comb[g]),
            .sel_high  (cfg_pol_high[g]),
            .sum_bit   (sum_term[g]),
            .oe_bit    (oe_term[g]),
            .pin_bit   (pin_in[g]),
            .drive_val (pin_out[g]),
            .drive_en  (pin_oe[g]),
            .fb_bit    (fb[g])
        );
    end

endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
    parameter int N_CELLS = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ar_term,
    input logic               sp_term,
    input logic               preload_en,
    input logic [N_CELLS-1:0] cfg_comb,
    input logic [N_CELLS-1:0] cfg_pol_high,
    input logic [N_CELLS-1:0] sum_term,
    input logic [N_CELLS-1:0] oe_term,
    input logic [N_CELLS-1:0] pin_in,
    input logic [N_CELLS-1:0] pin_out,
    input logic [N_CELLS-1:0] pin_oe,
    input logic [N_CELLS-1:0] fb
);

    localparam logic [N_CELLS-1:0] ZERO = '0;

    p_comb_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ sum_term ^ ~cfg_pol_high) & cfg_comb) == ZERO);

    p_sum_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_term && !sp_term && !preload_en) |=>
        (ar_term || ((fb ^ $past(sum_term)) & ~cfg_comb) == ZERO));

    p_comb_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fb ^ pin_in) & cfg_comb) == ZERO);

    p_clear_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ar_term |-> ((fb & ~cfg_comb) == ZERO));

    p_set_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_term && !ar_term) |=> (ar_term || ((~fb & ~cfg_comb) == ZERO)));

    p_reg_pol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ fb ^ ~cfg_pol_high) & ~cfg_comb) == ZERO);

    p_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en |-> (pin_oe == oe_term));

    p_load_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |-> (pin_oe == ZERO));

    p_pin_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !sp_term && !ar_term) |=>
        (ar_term || ((fb ^ $past(pin_in)) & ~cfg_comb) == ZERO));

    p_por_clear_r9: assert property (@(posedge clk)
        !rst_n |=> ((fb & ~cfg_comb) == ZERO));

endmodule

bind pld_macrocell pld_macrocell_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ar_term      (ar_term),
    .sp_term      (sp_term),
    .preload_en   (preload_en),
    .cfg_comb     (cfg_comb),
    .cfg_pol_high (cfg_pol_high),
    .sum_term     (sum_term),
    .oe_term      (oe_term),
    .pin_in       (pin_in),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .fb           (fb)
);

// File: tb/pld_macrocell_tb.sv
module pld_macrocell_tb;

    localparam int N = 4;
    localparam int ROWS = 9;
    // Cell 0 REG_LOW, cell 1 REG_HIGH, cell 2 COMB_LOW, cell 3 COMB_HIGH.
    localparam logic [N-1:0] CFG_C = 4'b1100;
    localparam logic [N-1:0] CFG_P = 4'b1010;

    // Row: {sum, oe, ar, sp, preload, ext, expected state}
    localparam logic [18:0] VEC [ROWS] = '{
        19'b1010_1111_000_0000_1010,
        19'b0101_1111_000_0000_0101,
        19'b1111_1111_010_0000_1111,
        19'b0011_1111_110_0000_0000,
        19'b0110_1111_000_0000_0110,
        19'b1111_1111_001_1001_1001,
        19'b1111_1111_011_0000_1111,
        19'b0000_0000_000_1010_0000,
        19'b1100_0101_000_0011_1100
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ar_term, sp_term, preload_en;
    logic [N-1:0] sum_term, oe_term, ext_drv, pin_in;
    logic [N-1:0] pin_out, pin_oe, fb;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    // Pin bus: the cell drives when enabled, otherwise the outside world.
    always_comb begin
        for (int i = 0; i < N; i++)
            pin_in[i] = pin_oe[i] ? pin_out[i] : ext_drv[i];
    end

    pld_macrocell #(.N_CELLS(N)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ar_term      (ar_term),
        .sp_term      (sp_term),
        .preload_en   (preload_en),
        .cfg_comb     (CFG_C),
        .cfg_pol_high (CFG_P),
        .sum_term     (sum_term),
        .oe_term      (oe_term),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .fb           (fb)
    );

    // Expected {pin_out, pin_oe, fb} from the requirements.
    function automatic logic [3*N-1:0] model(input logic [N-1:0] s, input logic [N-1:0] o,
                                             input logic pl, input logic [N-1:0] e,
                                             input logic [N-1:0] q);
        logic [N-1:0] eo, ee, ef;
        for (int i = 0; i < N; i++) begin
            eo[i] = (CFG_C[i] ? s[i] : q[i]) ^ ~CFG_P[i];
            ee[i] = o[i] & ~pl;
            ef[i] = CFG_C[i] ? (ee[i] ? eo[i] : e[i]) : q[i];
        end
        return {eo, ee, ef};
    endfunction

    task automatic check(input string req, input logic [N-1:0] q);
        logic [3*N-1:0] exp_v, act_v;
        exp_v = model(sum_term, oe_term, preload_en, ext_drv, q);
        act_v = {pin_out, pin_oe, fb};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: {out,oe,fb} actual %b expected %b", req, act_v, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; ar_term = 1'b0; sp_term = 1'b0; preload_en = 1'b0;
        sum_term = '0; oe_term = 4'b1111; ext_drv = '0;
        repeat (3) @(negedge clk);
        // R9: power-on state 0, registered pins show polarity of 0
        check("R9", 4'b0000);
        rst_n = 1'b1;

        // Vector table: R2 R3 R5 R6 R7 R8 and R1 on every row
        for (int r = 0; r < ROWS; r++) begin
            {sum_term, oe_term, ar_term, sp_term, preload_en, ext_drv} = VEC[r][18:4];
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R1 R2 R3 R5 R6 R7 R8 row %0d", r), VEC[r][3:0]);
        end

        // R2: plain load of registered cells
        {ar_term, sp_term, preload_en} = 3'b000;
        sum_term = 4'b0011; oe_term = 4'b1111; ext_drv = '0;
        @(posedge clk);
        @(negedge clk);
        check("R2 sum load", 4'b0011);

        // R4: clear acts with no clock edge
        #0.5 ar_term = 1'b1;
        #0.5 check("R4 immediate clear", 4'b0000);
        @(posedge clk);
        @(negedge clk);
        check("R4 clear held over edge", 4'b0000);
        ar_term = 1'b0;
        sum_term = 4'b0001;
        @(posedge clk);
        @(negedge clk);
        check("R2 R6 after clear release", 4'b0001);

        // R1: combinational cells follow sum without a clock
        #0.5 sum_term = 4'b0101;
        #0.5 check("R1 combinational follow", 4'b0001);

        // R7: disabled combinational pin feeds back the external level
        #0.5 oe_term = 4'b0011; ext_drv = 4'b1000;
        #0.5 check("R7 R3 input pin", 4'b0001);

        done = 1'b1;
        finish_run();
    end

endmodule